// File: doc/BRIEF.md
# Square-Root-Free Givens Rotation Cell

This block is one processing element of a triangular array that factorises a matrix by square-root-free Givens rotations. Every matrix element travels as a pair of single-precision numbers, a weight and a value, packed into one 64-bit word. The cell keeps its own pair (u, v) between operations and runs one of three operations on each accepted input. In boundary mode it absorbs an incoming element, updates its diagonal weight and produces the rotation (the new weight w̄ and the factor c) for its row. In internal mode it applies a rotation that arrives from its row to its stored pair and forwards the result. A load operation writes the pair and returns the previous one, which is how an array controller seeds the cell and reads results back.

Each operation is a fixed-length sequence of multiplies, adds and iterative divides over a shared arithmetic unit and two dividers. The result appears after a fixed number of cycles that depends only on the operation. Input and output both use a valid/ready handshake. The cell takes no new input until its last result has been taken.

Top module: `sgr_cell`

## Requirements
- R1: Each data word carries the weight in bits [63:32] and the value in bits [31:0], both in IEEE-754 single format. Results are truncated toward zero, and subnormal operands or results are treated as zero.
- R2: `in_mode` selects the operation: 2'b01 boundary, 2'b10 internal, 2'b00 or 2'b11 load.
- R3: Boundary with input (w, vk) and stored u, where u and ū are both nonzero: ū = u + w·vk·vk, c = vk/u, w̄ = w·u/ū. The output word is {w̄, vk}, `out_c` is c, and the stored pair becomes (ū, vk).
- R4: Boundary where u is zero or ū is zero: the output word equals the input word, `out_c` is zero, and the stored pair is left unchanged.
- R5: Internal with input (w, vk), `in_c` = c and stored (u, v): ū = u + w·vk·v and v̄ = v − c·u. The output word is {w, v̄}, `out_c` forwards c, and the stored pair becomes (ū, v̄).
- R6: Load stores the input word as (u, v), returns the previous pair as the output word, and sets `out_c` to zero.
- R7: After the clock edge that accepts an input, `out_valid` first rises at the 40th edge for boundary, the 39th for internal and the 2nd for load.
- R8: `in_ready` is high only when the cell is idle. `busy` is high from acceptance until the result is taken. Input offered while busy is ignored.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_word` and `out_c` hold their values.
- R10: After reset the stored pair is (0, 0), `out_valid` and `busy` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word and rotation are offered |
| in_ready | output | 1 | Cell is idle and takes input |
| in_mode | input | 2 | Operation select |
| in_word | input | 64 | Packed {weight, value} element |
| in_c | input | 32 | Rotation factor for internal mode |
| out_valid | output | 1 | Result is available |
| out_ready | input | 1 | Neighbour takes the result |
| out_word | output | 64 | Packed result word |
| out_c | output | 32 | Rotation factor sent along the row |
| busy | output | 1 | Operation in progress or result pending |

## Verification
On every cycle the assertions check the handshake rules: acceptance makes the cell busy and blocks further input, a stalled result holds steady, and a boundary result is only committed once both dividers are finished. The arithmetic cannot be checked that way. The bench shows it by running boundary and internal operations with chosen operands, including negative values and cancellations, and comparing them against a real-number model. It also shows the zero-denominator pass-through and the exact latency of each operation. A load read back after each step shows that the stored pair was updated, or left alone after bypassed and ignored inputs.

// File: rtl/sgr_pkg.sv
package sgr_pkg;

    localparam int FP_W   = 32;
    localparam int EXP_W  = 8;
    localparam int FRAC_W = 23;
    localparam int MANT_W = FRAC_W + 1;
    localparam int BIAS   = 127;
    localparam int EXP_MAX = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {OP_LOAD, OP_BOUND, OP_INT} op_e;
    typedef enum logic [1:0] {PH_IDLE, PH_RUN, PH_DONE} phase_e;

    function automatic logic fp_zero(input logic [FP_W-1:0] a);
        return a[FP_W-2:FRAC_W] == '0;
    endfunction

    function automatic logic [FP_W-1:0] fp_neg(input logic [FP_W-1:0] a);
        return {~a[FP_W-1], a[FP_W-2:0]};
    endfunction

    function automatic logic [FP_W-1:0] fp_pack(input logic s, input int e,
                                                input logic [FRAC_W-1:0] f);
        if (e <= 0)
            return {s, {(FP_W-1){1'b0}}};
        if (e >= EXP_MAX)
            return {s, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        return {s, EXP_W'(e), f};
    endfunction

    function automatic logic [FP_W-1:0] fp_mul(input logic [FP_W-1:0] a,
                                               input logic [FP_W-1:0] b);
        logic                  s;
        logic [2*MANT_W-1:0]   p;
        int                    e;
        logic [FRAC_W-1:0]     f;
        s = a[FP_W-1] ^ b[FP_W-1];
        if (fp_zero(a) || fp_zero(b))
            return {s, {(FP_W-1){1'b0}}};
        p = (2*MANT_W)'({1'b1, a[FRAC_W-1:0]}) * (2*MANT_W)'({1'b1, b[FRAC_W-1:0]});
        e = int'(a[FP_W-2:FRAC_W]) + int'(b[FP_W-2:FRAC_W]) - BIAS;
        if (p[2*MANT_W-1]) begin
            f = p[2*MANT_W-2:MANT_W];
            e = e + 1;
        end else begin
            f = p[2*MANT_W-3:MANT_W-1];
        end
        return fp_pack(s, e, f);
    endfunction

    function automatic logic [FP_W-1:0] fp_add(input logic [FP_W-1:0] a,
                                               input logic [FP_W-1:0] b);
        logic [FP_W-1:0]   x, y;
        logic [MANT_W+3:0] mx, my, m;
        int                e, d;
        if (fp_zero(a))
            return fp_zero(b) ? '0 : b;
        if (fp_zero(b))
            return a;
        if (a[FP_W-2:0] >= b[FP_W-2:0]) begin
            x = a; y = b;
        end else begin
            x = b; y = a;
        end
        e  = int'(x[FP_W-2:FRAC_W]);
        d  = e - int'(y[FP_W-2:FRAC_W]);
        mx = {2'b01, x[FRAC_W-1:0], 3'b000};
        my = {2'b01, y[FRAC_W-1:0], 3'b000};
        my = (d > MANT_W + 3) ? '0 : (my >> d);
        if (x[FP_W-1] == y[FP_W-1])
            m = mx + my;
        else
            m = mx - my;
        if (m == '0)
            return '0;
        if (m[MANT_W+3]) begin
            m = m >> 1;
            e = e + 1;
        end else begin
            for (int i = 0; i < MANT_W + 3; i++) begin
                if (!m[MANT_W+2]) begin
                    m = m << 1;
                    e = e - 1;
                end
            end
        end
        return fp_pack(x[FP_W-1], e, m[MANT_W+1:3]);
    endfunction

endpackage

// File: rtl/sgr_fpu.sv
module sgr_fpu
    import sgr_pkg::*;
(
    input  logic [FP_W-1:0] mul_a,
    input  logic [FP_W-1:0] mul_b,
    input  logic [FP_W-1:0] add_a,
    input  logic [FP_W-1:0] add_b,
    output logic [FP_W-1:0] prod,
    output logic [FP_W-1:0] sum
);
    always_comb begin
        prod = fp_mul(mul_a, mul_b);
        sum  = fp_add(add_a, add_b);
    end
endmodule

// File: rtl/sgr_fpdiv.sv
module sgr_fpdiv
    import sgr_pkg::*;
#(
    parameter int QBITS = MANT_W,
    localparam int REM_W = QBITS + 2,
    localparam int CNT_W = $clog2(QBITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [FP_W-1:0] num_i,
    input  logic [FP_W-1:0] den_i,
    output logic            busy_o,
    output logic            valid_o,
    output logic [FP_W-1:0] quot_o
);
    typedef struct packed {
        logic                     busy;
        logic                     valid;
        logic                     zero;
        logic                     sign;
        logic signed [EXP_W+1:0]  expo;
        logic [REM_W-1:0]         rem;
        logic [MANT_W-1:0]        den;
        logic [QBITS-1:0]         quot;
        logic [CNT_W-1:0]         cnt;
    } div_s;

    div_s st_d, st_q;

    always_comb begin
        int e;
        logic [MANT_W-1:0] mn, md;
        e    = 0;
        mn   = {1'b1, num_i[FRAC_W-1:0]};
        md   = {1'b1, den_i[FRAC_W-1:0]};
        st_d = st_q;
        if (start_i) begin
            st_d.busy  = 1'b0;
            st_d.valid = 1'b0;
            st_d.zero  = 1'b0;
            st_d.quot  = '0;
            st_d.sign  = num_i[FP_W-1] ^ den_i[FP_W-1];
            if (fp_zero(num_i) || fp_zero(den_i)) begin
                st_d.zero  = 1'b1;
                st_d.valid = 1'b1;
            end else begin
                e = int'(num_i[FP_W-2:FRAC_W]) - int'(den_i[FP_W-2:FRAC_W]) + BIAS;
                if (mn < md) begin
                    st_d.rem = REM_W'(mn) << 1;
                    e = e - 1;
                end else begin
                    st_d.rem = REM_W'(mn);
                end
                st_d.expo = (EXP_W+2)'(e);
                st_d.den  = md;
                st_d.cnt  = CNT_W'(QBITS);
                st_d.busy = 1'b1;
            end
        end else if (st_q.busy) begin
            if (st_q.rem >= REM_W'(st_q.den)) begin
                st_d.quot = {st_q.quot[QBITS-2:0], 1'b1};
                st_d.rem  = (st_q.rem - REM_W'(st_q.den)) << 1;
            end else begin
                st_d.quot = {st_q.quot[QBITS-2:0], 1'b0};
                st_d.rem  = st_q.rem << 1;
            end
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy  = 1'b0;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    always_comb begin
        busy_o  = st_q.busy;
        valid_o = st_q.valid;
        if (st_q.zero)
            quot_o = {st_q.sign, {(FP_W-1){1'b0}}};
        else
            quot_o = fp_pack(st_q.sign, int'(st_q.expo),
                             st_q.quot[QBITS-2 -: FRAC_W]);
    end

    // R3
    div_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !valid_o || st_q.zero);

    // R3
    div_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> valid_o);

endmodule

// File: rtl/sgr_cell.sv
module sgr_cell
    import sgr_pkg::*;
#(
    parameter int LAT_BOUND = 40,
    parameter int LAT_INT   = 39,
    parameter int LAT_LOAD  = 2,
    localparam int CNT_W    = $clog2(LAT_BOUND + LAT_INT + 1),
    localparam int WORD_W   = 2 * FP_W,
    localparam logic [3:0] STEP_FIN = 4'hF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [1:0]        in_mode,
    input  logic [WORD_W-1:0] in_word,
    input  logic [FP_W-1:0]   in_c,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_word,
    output logic [FP_W-1:0]   out_c,
    output logic              busy
);
    typedef struct packed {
        phase_e             phase;
        op_e                op;
        logic [3:0]         step;
        logic [CNT_W-1:0]   cnt;
        logic               bypass;
        logic [FP_W-1:0]    w;
        logic [FP_W-1:0]    vk;
        logic [FP_W-1:0]    cin;
        logic [FP_W-1:0]    u;
        logic [FP_W-1:0]    v;
        logic [FP_W-1:0]    t1;
        logic [FP_W-1:0]    t2;
        logic [FP_W-1:0]    ubar;
        logic [FP_W-1:0]    vbar;
        logic [WORD_W-1:0]  res_word;
        logic [FP_W-1:0]    res_c;
    } cell_s;

    cell_s cs_d, cs_q;

    logic [FP_W-1:0] mul_a, mul_b, add_a, add_b, prod, sum;
    logic            dc_start, dw_start;
    logic [FP_W-1:0] dw_num, dw_den;
    logic            dc_busy, dc_valid, dw_busy, dw_valid;
    logic [FP_W-1:0] dc_quot, dw_quot;
    logic            commit;

    sgr_fpu u_fpu (
        .mul_a (mul_a), .mul_b (mul_b),
        .add_a (add_a), .add_b (add_b),
        .prod  (prod),  .sum   (sum)
    );

    // divider for the rotation factor c = vk / u
    sgr_fpdiv u_div_c (
        .clk (clk), .rst_n (rst_n), .start_i (dc_start),
        .num_i (cs_q.vk), .den_i (cs_q.u),
        .busy_o (dc_busy), .valid_o (dc_valid), .quot_o (dc_quot)
    );

    // divider for the new weight w * u / ubar
    sgr_fpdiv u_div_w (
        .clk (clk), .rst_n (rst_n), .start_i (dw_start),
        .num_i (dw_num), .den_i (dw_den),
        .busy_o (dw_busy), .valid_o (dw_valid), .quot_o (dw_quot)
    );

    function automatic logic [CNT_W-1:0] lat_of(input op_e o);
        case (o)
            OP_BOUND: return CNT_W'(LAT_BOUND - 1);
            OP_INT:   return CNT_W'(LAT_INT - 1);
            default:  return CNT_W'(LAT_LOAD - 1);
        endcase
    endfunction

    always_comb begin
        cs_d     = cs_q;
        mul_a    = '0;
        mul_b    = '0;
        add_a    = '0;
        add_b    = '0;
        dc_start = 1'b0;
        dw_start = 1'b0;
        dw_num   = cs_q.t2;
        dw_den   = cs_q.ubar;
        commit   = 1'b0;

        // arithmetic sequence, one micro-step per cycle
        if (cs_q.phase == PH_RUN && cs_q.step != STEP_FIN) begin
            unique case (cs_q.op)
                OP_BOUND: begin
                    case (cs_q.step)
                        4'd0: begin
                            mul_a = cs_q.vk; mul_b = cs_q.vk;
                            cs_d.t1 = prod;
                            if (fp_zero(cs_q.u)) begin
                                cs_d.bypass = 1'b1;
                                cs_d.step   = STEP_FIN;
                            end else begin
                                dc_start  = 1'b1;
                                cs_d.step = 4'd1;
                            end
                        end
                        4'd1: begin
                            mul_a = cs_q.w; mul_b = cs_q.t1;
                            cs_d.t1   = prod;
                            cs_d.step = 4'd2;
                        end
                        4'd2: begin
                            add_a = cs_q.u; add_b = cs_q.t1;
                            cs_d.ubar = sum;
                            cs_d.step = 4'd3;
                        end
                        4'd3: begin
                            mul_a = cs_q.w; mul_b = cs_q.u;
                            cs_d.t2 = prod;
                            if (fp_zero(cs_q.ubar)) begin
                                cs_d.bypass = 1'b1;
                                cs_d.step   = STEP_FIN;
                            end else begin
                                cs_d.step = 4'd4;
                            end
                        end
                        4'd4: begin
                            dw_start  = 1'b1;
                            cs_d.step = 4'd5;
                        end
                        default: begin
                            if (dc_valid && dw_valid && !dc_busy && !dw_busy)
                                cs_d.step = STEP_FIN;
                        end
                    endcase
                end
                OP_INT: begin
                    case (cs_q.step)
                        4'd0: begin
                            mul_a = cs_q.w; mul_b = cs_q.vk;
                            cs_d.t1   = prod;
                            cs_d.step = 4'd1;
                        end
                        4'd1: begin
                            mul_a = cs_q.t1; mul_b = cs_q.v;
                            cs_d.t1   = prod;
                            cs_d.step = 4'd2;
                        end
                        4'd2: begin
                            add_a = cs_q.u; add_b = cs_q.t1;
                            cs_d.ubar = sum;
                            cs_d.step = 4'd3;
                        end
                        4'd3: begin
                            mul_a = cs_q.cin; mul_b = cs_q.u;
                            cs_d.t2   = prod;
                            cs_d.step = 4'd4;
                        end
                        default: begin
                            add_a = cs_q.v; add_b = fp_neg(cs_q.t2);
                            cs_d.vbar = sum;
                            cs_d.step = STEP_FIN;
                        end
                    endcase
                end
                default: cs_d.step = STEP_FIN;
            endcase
        end

        // phase control and fixed-latency count
        unique case (cs_q.phase)
            PH_IDLE: begin
                if (in_valid) begin
                    cs_d.phase  = PH_RUN;
                    cs_d.w      = in_word[WORD_W-1:FP_W];
                    cs_d.vk     = in_word[FP_W-1:0];
                    cs_d.cin    = in_c;
                    cs_d.step   = 4'd0;
                    cs_d.bypass = 1'b0;
                    case (in_mode)
                        2'b01:   cs_d.op = OP_BOUND;
                        2'b10:   cs_d.op = OP_INT;
                        default: cs_d.op = OP_LOAD;
                    endcase
                    cs_d.cnt = lat_of(cs_d.op);
                end
            end
            PH_RUN: begin
                if (cs_q.cnt == '0 && cs_q.step == STEP_FIN) begin
                    commit     = 1'b1;
                    cs_d.phase = PH_DONE;
                end else if (cs_q.cnt != '0) begin
                    cs_d.cnt = cs_q.cnt - 1'b1;
                end
            end
            default: begin
                if (out_ready)
                    cs_d.phase = PH_IDLE;
            end
        endcase

        // result and state update at the end of the sequence
        if (commit) begin
            unique case (cs_q.op)
                OP_BOUND: begin
                    if (cs_q.bypass) begin
                        cs_d.res_word = {cs_q.w, cs_q.vk};
                        cs_d.res_c    = '0;
                    end else begin
                        cs_d.res_word = {dw_quot, cs_q.vk};
                        cs_d.res_c    = dc_quot;
                        cs_d.u        = cs_q.ubar;
                        cs_d.v        = cs_q.vk;
                    end
                end
                OP_INT: begin
                    cs_d.res_word = {cs_q.w, cs_q.vbar};
                    cs_d.res_c    = cs_q.cin;
                    cs_d.u        = cs_q.ubar;
                    cs_d.v        = cs_q.vbar;
                end
                default: begin
                    cs_d.res_word = {cs_q.u, cs_q.v};
                    cs_d.res_c    = '0;
                    cs_d.u        = cs_q.w;
                    cs_d.v        = cs_q.vk;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cs_q <= '0;
        else
            cs_q <= cs_d;
    end

    assign in_ready  = (cs_q.phase == PH_IDLE);
    assign out_valid = (cs_q.phase == PH_DONE);
    assign busy      = (cs_q.phase != PH_IDLE);
    assign out_word  = cs_q.res_word;
    assign out_c     = cs_q.res_c;

    // R8
    accept_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> busy && !in_ready && !out_valid);

    // R8
    result_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_word) && $stable(out_c));

    // R3
    div_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit && cs_q.op == OP_BOUND && !cs_q.bypass |-> dc_valid && dw_valid);

    // R7
    no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(cs_q.cnt) == '0);

endmodule

// File: tb/sim_sgr_cell.sv
module sim_sgr_cell;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_mode = 2'b00;
    logic [63:0] in_word = '0;
    logic [31:0] in_c = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_word;
    logic [31:0] out_c;
    logic        busy;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    real mu = 0.0;
    real mv = 0.0;

    always #5 clk = ~clk;

    sgr_cell u0 (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_mode (in_mode), .in_word (in_word), .in_c (in_c),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_word (out_word), .out_c (out_c), .busy (busy)
    );

    // real to single precision, truncated toward zero (R1)
    function automatic logic [31:0] f32(input real r);
        logic [63:0] b;
        int e;
        if (r == 0.0) return 32'h0;
        b = $realtobits(r);
        e = int'(b[62:52]) - 1023 + 127;
        return {b[63], 8'(e), b[51:29]};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] m, input logic [63:0] word, input logic [31:0] c,
                        output logic [63:0] ow, output logic [31:0] oc, output int lat);
        @(negedge clk);
        in_mode = m; in_word = word; in_c = c; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        lat = 0;
        while (!out_valid && lat < 200) begin
            @(posedge clk); #1;
            lat++;
        end
        @(negedge clk);
        ow = out_word; oc = out_c;
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
    endtask

    task automatic t_reset();
        chk("R10 out_valid", 64'(out_valid), 64'd0);
        chk("R10 in_ready", 64'(in_ready), 64'd1);
        chk("R10 busy", 64'(busy), 64'd0);
    endtask

    task automatic t_load(input logic [1:0] m, input real nu, input real nv);
        logic [63:0] ow; logic [31:0] oc; int lat;
        xfer(m, {f32(nu), f32(nv)}, 32'h0, ow, oc, lat);
        chk("R6 old pair", ow, {f32(mu), f32(mv)});
        chk("R6 c zero", 64'(oc), 64'd0);
        chk("R7 load latency", 64'(lat), 64'd2);
        mu = nu; mv = nv;
    endtask

    task automatic t_bound(input real w, input real vk);
        logic [63:0] ow; logic [31:0] oc; int lat;
        real ub;
        ub = mu + w * vk * vk;
        xfer(2'b01, {f32(w), f32(vk)}, 32'h0, ow, oc, lat);
        chk("R7 boundary latency", 64'(lat), 64'd40);
        if (mu == 0.0 || ub == 0.0) begin
            chk("R4 word passes", ow, {f32(w), f32(vk)});
            chk("R4 c zero", 64'(oc), 64'd0);
        end else begin
            chk("R3 word", ow, {f32(w * mu / ub), f32(vk)});
            chk("R3 c", 64'(oc), 64'(f32(vk / mu)));
            mu = ub; mv = vk;
        end
    endtask

    task automatic t_int(input real w, input real vk, input real c);
        logic [63:0] ow; logic [31:0] oc; int lat;
        real ub, vb;
        ub = mu + w * vk * mv;
        vb = mv - c * mu;
        xfer(2'b10, {f32(w), f32(vk)}, f32(c), ow, oc, lat);
        chk("R7 internal latency", 64'(lat), 64'd39);
        chk("R5 word", ow, {f32(w), f32(vb)});
        chk("R5 c forwarded", 64'(oc), 64'(f32(c)));
        mu = ub; mv = vb;
    endtask

    // busy blocking, ignored input and stalled output (R8, R9)
    task automatic t_busy_stall();
        logic [63:0] hold_w; logic [31:0] hold_c;
        @(negedge clk);
        in_mode = 2'b01; in_word = {f32(0.0), f32(5.0)}; in_c = '0; in_valid = 1'b1;
        @(posedge clk); #1;
        in_mode = 2'b00; in_word = {f32(77.0), f32(88.0)};
        repeat (10) @(posedge clk);
        #1;
        chk("R8 busy during op", 64'(busy), 64'd1);
        chk("R8 in_ready low", 64'(in_ready), 64'd0);
        while (!out_valid) begin @(posedge clk); #1; end
        in_valid = 1'b0;
        hold_w = out_word; hold_c = out_c;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R9 valid held", 64'(out_valid), 64'd1);
        chk("R9 word held", out_word, hold_w);
        chk("R9 c held", 64'(out_c), 64'(hold_c));
        chk("R3 w zero result", hold_w, {f32(0.0), f32(5.0)});
        chk("R3 c one", 64'(hold_c), 64'(f32(1.0)));
        out_ready = 1'b1;
        @(posedge clk); #1;
        out_ready = 1'b0;
        chk("R8 idle after take", 64'(busy), 64'd0);
        mu = 5.0; mv = 5.0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        t_reset();
        t_load(2'b00, 4.0, 7.0);      // R10 reset pair read back
        t_bound(1.0, 2.0);
        t_load(2'b00, 6.0, 1.0);
        t_bound(0.5, 6.0);
        t_load(2'b00, 2.0, 5.0);
        t_int(0.5, 4.0, 0.25);
        t_load(2'b00, 1.0, -3.0);
        t_int(2.0, 1.0, -2.0);
        t_load(2'b00, 0.0, 9.0);
        t_bound(3.0, 5.0);            // R4 u zero
        t_load(2'b00, 2.0, 1.0);
        t_bound(-0.5, 2.0);           // R4 ubar zero
        t_load(2'b00, 3.0, 3.0);
        t_load(2'b11, 5.0, 5.0);      // R2 mode 11 loads
        t_busy_stall();
        t_load(2'b00, 1.0, 1.0);      // R8 ignored input left no trace
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule